// File: doc/BRIEF.md
# SPI Ferroelectric Byte Memory Model

This block is a synthesizable SPI slave that answers like a byte-addressed ferroelectric nonvolatile memory. It listens on a four-wire bus (active-low chip select, serial clock, MOSI, MISO) in SPI mode 3. The clock idles high, transfers are 8 bits, most significant bit first, and the slave changes MISO after each falling clock edge so that the master can sample it on the rising edge. The bus pins are oversampled by the system clock, so the serial clock must be much slower than the system clock.

Each transaction begins with a one-byte opcode. The block supports write-latch set and clear, status read and write, memory read and write, and an identification read. It stores its bytes in an inferable block RAM of `MEM_BYTES` entries and keeps a status register with a write-enable latch, a protect code and a lock bit. A write commits at once, so the busy flag never shows. Capacity and variant codes for the identification reply are parameters, and so is the number of address bytes (2 or 3).

Top module: `fram_spi_model`

## Requirements
- R1: While chip select is high, and after reset, MISO is 0. After reset the status register reads 0x00.
- R2: Opcode 0x9F returns six bytes of 0x7F, then 0xC2, then `CAP_CODE`, then `VARIANT_CODE`. Every later byte in the same transaction is 0x00.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch reads back as status bit 1.
- R4: Opcode 0x02, followed by the address and then data bytes, stores the data. Opcode 0x03, followed by the address, returns stored bytes for as long as chip select stays low.
- R5: After each data byte the address advances by one. Past `MEM_BYTES-1` it wraps to 0, for both reads and writes.
- R6: While the write-enable latch is clear, data writes and status writes change nothing.
- R7: When chip select rises at the end of a 0x02 or 0x01 transaction, the write-enable latch is cleared.
- R8: Opcode 0x05 returns the status byte on every following byte of the transaction. The layout is bit 7 lock, bits 4:2 protect code, bit 1 latch, and bits 6:5 and bit 0 always 0. Opcode 0x01 with the latch set loads bit 7 and bits 4:2 from its first data byte.
- R9: Protect code c protects a top region of the array. For c=0 nothing is protected and for c=7 the whole array is protected. For 1 to 6 the region is every address at or above `MEM_BYTES - MEM_BYTES/2^(7-c)`. Writes to that region are dropped.
- R10: The address takes `ADDR_BYTES` bytes, high byte first. Address bits at and above log2(`MEM_BYTES`) are ignored.
- R11: An opcode that is not in the set above returns 0x00 on every following byte and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles high (mode 3) |
| spi_mosi | input | 1 | Serial data from the master, MSB first |
| spi_miso | output | 1 | Serial data to the master, registered, 0 while deselected |

## Verification
The main data path is exercised with three kinds of traffic:
- A full-array fill followed by short reads, which separates correct storage from address or shift errors.
- A burst that crosses the top of the array, which shows whether the address wraps or spills.
- Addresses that differ only in their ignored high bits, which show whether the upper address byte leaks into the decode.

The protection and latch gating get their own patterns. Each protect code is tried with a two-byte write that straddles its region boundary, so an off-by-one in the region edge shows up as a wrong byte on the first or second address. Writes and status writes with the latch clear, and an unknown opcode, are read back to show that they have no effect.

// File: rtl/fram_pkg.sv
package fram_pkg;
  localparam logic [7:0] OPC_LATCH_SET = 8'h06;
  localparam logic [7:0] OPC_LATCH_CLR = 8'h04;
  localparam logic [7:0] OPC_STAT_RD   = 8'h05;
  localparam logic [7:0] OPC_STAT_WR   = 8'h01;
  localparam logic [7:0] OPC_MEM_RD    = 8'h03;
  localparam logic [7:0] OPC_MEM_WR    = 8'h02;
  localparam logic [7:0] OPC_ID_RD     = 8'h9F;

  localparam logic [7:0] ID_CONT_CODE  = 8'h7F;
  localparam logic [7:0] ID_TYPE_CODE  = 8'hC2;
  localparam int         ID_CONT_COUNT = 6;
  localparam int         ID_LEN        = 9;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_RDATA,
    PH_WDATA,
    PH_STAT_RD,
    PH_STAT_WR,
    PH_ID,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/fram_spi_shifter.sv
module fram_spi_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_csn,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic [7:0] tx_byte,
  output logic       cs_active,
  output logic       cs_rise,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  // two-stage synchronizers plus one history stage for edge detection
  logic [1:0] csn_s;
  logic       csn_prev;
  logic [2:0] sck_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] tx_sr;
  logic       sck_rise, sck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_s    <= 2'b11;
      csn_prev <= 1'b1;
      sck_s    <= 3'b111;
      mosi_s   <= 2'b00;
    end else begin
      csn_s    <= {csn_s[0], spi_csn};
      csn_prev <= csn_s[1];
      sck_s    <= {sck_s[1:0], spi_sck};
      mosi_s   <= {mosi_s[0], spi_mosi};
    end
  end

  assign cs_active = !csn_s[1];
  assign cs_rise   = csn_s[1] && !csn_prev;
  assign sck_rise  = sck_s[1] && !sck_s[2];
  assign sck_fall  = !sck_s[1] && sck_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= 3'd0;
      shreg     <= 7'd0;
      tx_sr     <= 8'd0;
      byte_done <= 1'b0;
      rx_byte   <= 8'd0;
      miso      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_active) begin
        bit_cnt <= 3'd0;
        tx_sr   <= 8'd0;
        miso    <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg   <= {shreg[5:0], mosi_s[1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {shreg, mosi_s[1]};
          end
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0) begin
            miso  <= tx_byte[7];
            tx_sr <= {tx_byte[6:0], 1'b0};
          end else begin
            miso  <= tx_sr[7];
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/fram_prot_decode.sv
module fram_prot_decode #(
  parameter int AW = 8
) (
  input  logic [2:0]    prot_code,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  // code c (1..6): protected when the top 7-c address bits are all ones
  always_comb begin
    if (prot_code == 3'd0) begin
      hit = 1'b0;
    end else if (prot_code == 3'd7) begin
      hit = 1'b1;
    end else begin
      hit = 1'b1;
      for (int k = 0; k < 6; k++) begin
        if ((k < 7 - int'(prot_code)) && !addr[AW-1-k]) hit = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fram_mem_array.sv
module fram_mem_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fram_cmd_ctrl.sv
module fram_cmd_ctrl
  import fram_pkg::*;
#(
  parameter int          ADDR_BYTES   = 2,
  parameter int          AW           = 8,
  parameter logic [7:0]  CAP_CODE     = 8'h21,
  parameter logic [7:0]  VARIANT_CODE = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_active,
  input  logic          cs_rise,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic [7:0]    rdata,
  input  logic          prot_hit,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] ptr,
  output logic          mem_we,
  output logic          wlatch,
  output logic [2:0]    prot_code,
  output logic          wr_seen
);
  localparam logic [1:0] LAST_ADDR = 2'(ADDR_BYTES - 1);
  localparam logic [3:0] ID_END    = 4'(ID_LEN);

  phase_e       phase;
  logic [1:0]   addr_cnt;
  logic [3:0]   id_idx;
  logic         rd_mode;
  logic         stat_lock;
  logic [AW+7:0] addr_cat;
  logic [7:0]   status_byte;
  logic [7:0]   id_byte;

  assign addr_cat    = {ptr, rx_byte};
  assign status_byte = {stat_lock, 2'b00, prot_code, wlatch, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_OPCODE;
      addr_cnt  <= 2'd0;
      id_idx    <= 4'd0;
      rd_mode   <= 1'b0;
      ptr       <= '0;
      wlatch    <= 1'b0;
      prot_code <= 3'd0;
      stat_lock <= 1'b0;
      wr_seen   <= 1'b0;
    end else begin
      if (cs_rise && wr_seen) wlatch <= 1'b0;
      if (!cs_active) begin
        phase    <= PH_OPCODE;
        addr_cnt <= 2'd0;
        id_idx   <= 4'd0;
        wr_seen  <= 1'b0;
      end else if (byte_done) begin
        unique case (phase)
          PH_OPCODE: begin
            case (rx_byte)
              OPC_LATCH_SET: begin wlatch <= 1'b1; phase <= PH_SKIP; end
              OPC_LATCH_CLR: begin wlatch <= 1'b0; phase <= PH_SKIP; end
              OPC_STAT_RD:   phase <= PH_STAT_RD;
              OPC_STAT_WR:   begin phase <= PH_STAT_WR; wr_seen <= 1'b1; end
              OPC_MEM_RD:    begin phase <= PH_ADDR; rd_mode <= 1'b1; end
              OPC_MEM_WR:    begin phase <= PH_ADDR; rd_mode <= 1'b0; wr_seen <= 1'b1; end
              OPC_ID_RD:     phase <= PH_ID;
              default:       phase <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            ptr      <= addr_cat[AW-1:0];
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == LAST_ADDR) phase <= rd_mode ? PH_RDATA : PH_WDATA;
          end
          PH_RDATA, PH_WDATA: ptr <= ptr + 1'b1;
          PH_STAT_WR: begin
            if (wlatch) begin
              stat_lock <= rx_byte[7];
              prot_code <= rx_byte[4:2];
            end
            phase <= PH_SKIP;
          end
          PH_ID: if (id_idx != ID_END) id_idx <= id_idx + 4'd1;
          default: ;
        endcase
      end
    end
  end

  assign mem_we = cs_active && byte_done && (phase == PH_WDATA) && wlatch && !prot_hit;

  always_comb begin
    if (id_idx < 4'(ID_CONT_COUNT))          id_byte = ID_CONT_CODE;
    else if (id_idx == 4'(ID_CONT_COUNT))     id_byte = ID_TYPE_CODE;
    else if (id_idx == 4'(ID_CONT_COUNT + 1)) id_byte = CAP_CODE;
    else if (id_idx == 4'(ID_CONT_COUNT + 2)) id_byte = VARIANT_CODE;
    else                                      id_byte = 8'h00;
  end

  always_comb begin
    case (phase)
      PH_RDATA:   tx_byte = rdata;
      PH_STAT_RD: tx_byte = status_byte;
      PH_ID:      tx_byte = id_byte;
      default:    tx_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/fram_spi_model.sv
module fram_spi_model #(
  parameter int         ADDR_BYTES   = 2,
  parameter int         MEM_BYTES    = 256,
  parameter logic [7:0] CAP_CODE     = 8'h21,
  parameter logic [7:0] VARIANT_CODE = 8'h00
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW = $clog2(MEM_BYTES);

  logic          cs_active, cs_rise, byte_done;
  logic [7:0]    rx_byte, tx_byte, rdata;
  logic [AW-1:0] ptr;
  logic          mem_we, wlatch, wr_seen, prot_hit;
  logic [2:0]    prot_code;

  fram_spi_shifter u_shifter (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .tx_byte(tx_byte), .cs_active(cs_active), .cs_rise(cs_rise),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  fram_prot_decode #(.AW(AW)) u_prot (
    .prot_code(prot_code), .addr(ptr), .hit(prot_hit)
  );

  fram_mem_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(rx_byte), .raddr(ptr), .rdata(rdata)
  );

  fram_cmd_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .AW(AW), .CAP_CODE(CAP_CODE), .VARIANT_CODE(VARIANT_CODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_active(cs_active), .cs_rise(cs_rise),
    .byte_done(byte_done), .rx_byte(rx_byte), .rdata(rdata), .prot_hit(prot_hit),
    .tx_byte(tx_byte), .ptr(ptr), .mem_we(mem_we), .wlatch(wlatch),
    .prot_code(prot_code), .wr_seen(wr_seen)
  );
endmodule

// File: rtl/fram_spi_model_checker.sv
module fram_spi_model_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          spi_csn,
  input logic          spi_miso,
  input logic          cs_rise,
  input logic          wr_seen,
  input logic          wlatch,
  input logic [2:0]    prot_code,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  localparam int MEM = 1 << AW;

  logic [2:0] age;
  logic       prot_ref;

  always_ff @(posedge clk) begin
    if (rst) age <= 3'd0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // region computed by arithmetic threshold, independent of the bit-pattern decoder
  always_comb begin
    case (prot_code)
      3'd0:    prot_ref = 1'b0;
      3'd7:    prot_ref = 1'b1;
      default: prot_ref = (int'(mem_addr) >= MEM - (MEM >> (7 - int'(prot_code))));
    endcase
  end

  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |-> !spi_miso);

  assert_latch_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && wr_seen) |=> !wlatch);

  assert_write_needs_latch_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wlatch);

  assert_status_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && prot_code != $past(prot_code)) |-> $past(wlatch));

  assert_region_guard_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !prot_ref);
endmodule

bind fram_spi_model fram_spi_model_checker #(.AW(AW)) u_checker (
  .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_miso(spi_miso),
  .cs_rise(cs_rise), .wr_seen(wr_seen), .wlatch(wlatch),
  .prot_code(prot_code), .mem_we(mem_we), .mem_addr(ptr)
);

// File: tb/fram_spi_model_bench.sv
`timescale 1ns/1ps
module fram_spi_model_bench;
  localparam int MEM = 256;
  localparam int HP  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_csn = 1'b1, spi_sck = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;

  always #2.5 clk = ~clk;

  fram_spi_model #(.ADDR_BYTES(2), .MEM_BYTES(MEM), .CAP_CODE(8'h21), .VARIANT_CODE(8'h00))
    u_fram_spi_model (.clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
                      .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  typedef struct { bit chk; logic [7:0] val; string tag; } exp_t;
  exp_t expq[$];

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  logic [7:0] model_mem [MEM];
  bit         m_wl = 0, m_lock = 0;
  logic [2:0] m_prot = 3'd0;

  function automatic bit is_prot(int a, logic [2:0] c);
    if (c == 3'd0) return 1'b0;
    if (c == 3'd7) return 1'b1;
    return (a >= MEM - (MEM >> (7 - int'(c))));
  endfunction

  task automatic check_val(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: assembles MISO bytes on rising clock edges and pops expectations
  initial begin
    logic [7:0] sh;
    int nb;
    exp_t it;
    nb = 0; sh = 8'h00;
    forever begin
      @(posedge spi_sck or posedge spi_csn);
      if (spi_csn) nb = 0;
      else begin
        sh = {sh[6:0], spi_miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          it = expq.pop_front();
          if (it.chk) check_val(it.tag, sh, it.val);
        end
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, input bit c, input logic [7:0] e, input string tag);
    exp_t it;
    it.chk = c; it.val = e; it.tag = tag;
    expq.push_back(it);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); spi_sck = 1'b0; spi_mosi = tx[i];
      repeat (HP) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HP - 1) @(negedge clk);
    end
  endtask

  task automatic cs_on();
    @(negedge clk); spi_csn = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HP) @(negedge clk); spi_csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic op_single(input logic [7:0] op);
    cs_on(); xfer(op, 0, 8'h00, ""); cs_off();
  endtask

  task automatic set_latch(); op_single(8'h06); m_wl = 1; endtask
  task automatic clr_latch(); op_single(8'h04); m_wl = 0; endtask

  task automatic read_status(input string tag);
    logic [7:0] e;
    e = {m_lock, 2'b00, m_prot, m_wl, 1'b0};
    cs_on(); xfer(8'h05, 0, 8'h00, "");
    xfer(8'h00, 1, e, tag); xfer(8'hFF, 1, e, tag);
    cs_off();
  endtask

  task automatic write_status(input logic [7:0] v);
    cs_on(); xfer(8'h01, 0, 8'h00, ""); xfer(v, 0, 8'h00, ""); cs_off();
    if (m_wl) begin m_lock = v[7]; m_prot = v[4:2]; end
    m_wl = 0;
  endtask

  task automatic send_addr(input int a);
    xfer(8'((a >> 8) & 255), 0, 8'h00, "");
    xfer(8'(a & 255), 0, 8'h00, "");
  endtask

  task automatic write_data(input int a, input int n, input logic [7:0] seed);
    cs_on(); xfer(8'h02, 0, 8'h00, ""); send_addr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      int idx;
      v = 8'(int'(seed) + i * 7);
      idx = (a + i) % MEM;
      xfer(v, 0, 8'h00, "");
      if (m_wl && !is_prot(idx, m_prot)) model_mem[idx] = v;
    end
    cs_off();
    m_wl = 0;
  endtask

  task automatic read_data(input int a, input int n, input string tag);
    cs_on(); xfer(8'h03, 0, 8'h00, ""); send_addr(a);
    for (int i = 0; i < n; i++) xfer(8'hA5, 1, model_mem[(a + i) % MEM], tag);
    cs_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check_val("R1 miso after reset", {7'd0, spi_miso}, 8'h00);
    read_status("R1");

    // R2 identification sequence, then zero fill
    cs_on(); xfer(8'h9F, 0, 8'h00, "");
    for (int i = 0; i < 6; i++) xfer(8'h00, 1, 8'h7F, "R2");
    xfer(8'h00, 1, 8'hC2, "R2"); xfer(8'h00, 1, 8'h21, "R2");
    xfer(8'h00, 1, 8'h00, "R2"); xfer(8'h00, 1, 8'h00, "R2");
    cs_off();

    // R3 latch set / clear
    set_latch(); read_status("R3");
    clr_latch(); read_status("R3");

    // R4 fill whole array, latch dropped afterwards (R7)
    set_latch(); write_data(0, MEM, 8'h11);
    read_status("R7");
    read_data(0, 6, "R4");
    read_data(200, 5, "R4");

    // R6 write without latch is ignored
    write_data(16, 3, 8'hE0);
    read_data(16, 3, "R6");

    // R5 write burst across the top, continuous read across the wrap
    set_latch(); write_data(MEM - 2, 4, 8'h90);
    read_data(MEM - 4, 8, "R5");

    // R10 ignored high address bits
    set_latch(); write_data(16'h3720, 2, 8'h44);
    read_data(16'h0020, 2, "R10");
    read_data(16'hFF20, 2, "R10");

    // R8 status write; R9 whole-array protection
    set_latch(); write_status(8'hFF);
    read_status("R8");
    write_status(8'h00);           // latch clear: no effect
    read_status("R6");
    set_latch(); write_data(64, 2, 8'h5C);
    read_data(64, 2, "R9");

    // R9 each partial code straddling its boundary
    for (int c = 1; c <= 6; c++) begin
      int b;
      b = MEM - (MEM >> (7 - c));
      set_latch(); write_status(8'(c << 2));
      set_latch(); write_data(b - 1, 2, 8'(c * 16 + 3));
      read_data(b - 1, 2, "R9");
    end
    set_latch(); write_status(8'h00);
    set_latch(); write_data(MEM - 1, 1, 8'hC1);
    read_data(MEM - 1, 1, "R9");

    // R11 unknown opcode
    set_latch();
    cs_on(); xfer(8'hC3, 0, 8'h00, "");
    xfer(8'h00, 1, 8'h00, "R11"); xfer(8'h00, 1, 8'h00, "R11");
    cs_off();
    read_status("R11");

    wait (expq.size() == 0);
    repeat (20) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule